// File: doc/BRIEF.md
# Byte-Lane Read-Merge-Write Memory Controller

This block is a bus slave placed in front of a word-wide memory that offers a single whole-word write strobe and no per-byte write control. A 32-bit master may still write any subset of the four byte lanes. The controller emulates the missing byte strobes internally. It fetches the current word, replaces only the lanes the master enabled, and stores the combined word back before it acknowledges.

Reads and writes follow the same fixed three-phase sequence, so the master always sees the same latency. The bus and memory data lanes line up bit for bit. The master raises its select strobe together with a direction bit, an address, write data and four lane enables. It holds them until the acknowledge pulse, then drops the strobe. The memory is expected to return registered read data one clock after it sees an address.

Top module: `rmw_bytelane_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, `bus_ack` and `mem_we` are low.
- R2: A read accepted at clock edge k (strobe high while idle) is acknowledged during the cycle that follows edge k+2. `bus_rdata` then carries the memory word stored at the requested address.
- R3: A write accepted at edge k is acknowledged with the same timing as a read. `mem_we` is high in that same cycle and in no other cycle of the access.
- R4: `bus_ack` is high for exactly one cycle per access.
- R5: `mem_we` is never asserted during a read access.
- R6: For a write, lane enable bit i (bit 0 = bits 7:0, bit 3 = bits 31:24) set causes memory bits 8i+7:8i to take the bus write data of that lane.
- R7: For a write, every lane whose enable bit is clear keeps the memory contents it held before the access.
- R8: A write with all four enables clear still asserts `mem_we` and stores the word back unchanged.
- R9: A write with all four enables set takes the same three-phase latency as any other write.
- R10: While an access is in progress, changes on `bus_addr`, `bus_wdata`, `bus_ben` and `bus_write` have no effect on that access. Only the values present at acceptance are used.
- R11: `mem_addr` stays constant from the cycle after acceptance until the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request strobe from the master |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data from the master |
| bus_ben | input | DATA_W/8 | Byte lane enables, bit i for bits 8i+7:8i |
| bus_rdata | output | DATA_W | Read data, valid while `bus_ack` is high on a read |
| bus_ack | output | 1 | One-cycle access acknowledge |
| mem_addr | output | ADDR_W | Word address to the memory |
| mem_rdata | input | DATA_W | Registered read data from the memory |
| mem_wdata | output | DATA_W | Combined word written to the memory |
| mem_we | output | 1 | Whole-word write enable to the memory |

## Verification
Writes are tried with every kind of lane pattern: single lanes, which reveal a lane swapped with a neighbour, and the empty pattern, which shows whether the write-back still occurs. The full pattern shows whether it shortcuts the latency. Random mixed patterns aimed at a small group of addresses stack partial updates on the same word, so a merge that ignores old contents or reads a stale word diverges from the byte-level reference model. A burst of bus activity during a busy access separates a design that latches its request from one that samples the bus late. Every access is timed from acceptance to acknowledge, and the acknowledge and write strobe are compared with a phase model on every clock.

// File: rtl/rmw_ctrl_pkg.sv
package rmw_ctrl_pkg;
    // Phases of one access; every access walks all three busy phases.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ADDR   = 2'd1,  // address held to memory, memory fetching
        PH_MERGE  = 2'd2,  // fetched word available, combine lanes
        PH_COMMIT = 2'd3   // store combined word, acknowledge
    } rmw_phase_e;
endpackage

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int NUM_LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0]    old_word,
    input  logic [DATA_W-1:0]    new_word,
    input  logic [NUM_LANES-1:0] lane_en,
    output logic [DATA_W-1:0]    merged
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Each lane picks its source independently of the others.
        assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_word[g*LANE_W +: LANE_W]
                                                       : old_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
    import rmw_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_sel,
    output rmw_phase_e phase,
    output logic       accept,
    output logic       busy
);
    typedef struct packed {
        rmw_phase_e ph;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_sel) begin
                    accept   = 1'b1;
                    st_d.ph  = PH_ADDR;
                end
            end
            PH_ADDR:   st_d.ph = PH_MERGE;
            PH_MERGE:  st_d.ph = PH_COMMIT;
            PH_COMMIT: st_d.ph = PH_IDLE;
            default:   st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE};
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign busy  = (st_q.ph != PH_IDLE);
endmodule

// File: rtl/rmw_bytelane_ctrl.sv
module rmw_bytelane_ctrl
    import rmw_ctrl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int LANE_W = 8,
    localparam int NUM_LANES = DATA_W / LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_LANES-1:0] bus_ben,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_we
);
    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic [NUM_LANES-1:0] ben;
        logic                 write;
        logic [DATA_W-1:0]    word;   // merged word (write) or fetched word (read)
    } dp_state_t;

    dp_state_t  dp_d, dp_q;
    rmw_phase_e phase;
    logic       accept;
    logic       seq_busy;
    logic [DATA_W-1:0] merged;

    rmw_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_sel(bus_sel),
        .phase  (phase),
        .accept (accept),
        .busy   (seq_busy)
    );

    rmw_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
        .old_word(mem_rdata),
        .new_word(dp_q.wdata),
        .lane_en (dp_q.ben),
        .merged  (merged)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.addr  = bus_addr;
            dp_d.wdata = bus_wdata;
            dp_d.ben   = bus_ben;
            dp_d.write = bus_write;
        end
        if (phase == PH_MERGE) begin
            dp_d.word = dp_q.write ? merged : mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign mem_addr  = dp_q.addr;
    assign mem_wdata = dp_q.word;
    assign mem_we    = (phase == PH_COMMIT) && dp_q.write;
    assign bus_ack   = (phase == PH_COMMIT);
    assign bus_rdata = dp_q.word;
endmodule

// File: rtl/rmw_bytelane_checker.sv
module rmw_bytelane_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy
);
    // R1: nothing toggles toward bus or memory while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_ack && !mem_we));

    // R4: acknowledge lasts one cycle
    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R3, R5: the memory is written only in an acknowledge cycle
    a_r3_we_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> bus_ack);

    // R2, R9: acknowledge comes three cycles after the strobe was seen
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_sel, 3));

    // R11: memory address is held through the whole access
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

bind rmw_bytelane_ctrl rmw_bytelane_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_ack (bus_ack),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .busy    (seq_busy)
);

// File: tb/sim_rmw_bytelane_ctrl.sv
`timescale 1ns/1ps
module sim_rmw_bytelane_ctrl;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NL = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [NL-1:0] bus_ben = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    rmw_bytelane_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    // Word memory with registered, read-before-write output
    logic [DW-1:0] mem [DEPTH];
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Byte-level reference contents
    logic [7:0] ref_b [DEPTH*NL];

    // Behavioural phase model: 0 idle, 1..3 busy, ack at 3
    int  m_phase = 0;
    bit  m_write = 0;
    always @(posedge clk) begin
        if (!rst_n) m_phase <= 0;
        else if (m_phase == 0) begin
            if (bus_sel) begin m_phase <= 1; m_write <= bus_write; end
        end else if (m_phase == 3) m_phase <= 0;
        else m_phase <= m_phase + 1;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (bus_ack !== (m_phase == 3)) begin
                errors++;
                $display("FAIL R4 ack per-clock: got %0b expected %0b", bus_ack, m_phase == 3);
            end
            checks++;
            if (mem_we !== (m_phase == 3 && m_write)) begin
                errors++;
                $display("FAIL R5 mem_we per-clock: got %0b expected %0b", mem_we, m_phase == 3 && m_write);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input int a);
        logic [31:0] w;
        for (int i = 0; i < NL; i++) w[i*8 +: 8] = ref_b[a*NL + i];
        return w;
    endfunction

    // One access; perturb=1 scrambles the bus while busy (R10)
    task automatic access(input bit wr, input int a, input logic [31:0] d, input logic [3:0] be,
                          input bit perturb, output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = wr; bus_addr = AW'(a); bus_wdata = d; bus_ben = be;
        lat = 0;
        rd = '0;
        while (lat < 20) begin
            @(negedge clk);
            lat++;
            if (perturb) begin
                bus_addr = ~bus_addr; bus_wdata = ~bus_wdata; bus_ben = ~bus_ben; bus_write = ~bus_write;
            end
            if (bus_ack) begin rd = bus_rdata; break; end
        end
        bus_sel = 1'b0;
        if (wr) for (int i = 0; i < NL; i++) if (be[i]) ref_b[a*NL + i] = d[i*8 +: 8];
    endtask

    task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be,
                            input bit perturb, input string req);
        logic [31:0] rd; int lat;
        access(1'b1, a, d, be, perturb, rd, lat);
        check(lat == 3, {req, " write latency"}, lat, 3);
    endtask

    task automatic do_read(input int a, input string req);
        logic [31:0] rd; int lat;
        access(1'b0, a, '0, '0, 1'b0, rd, lat);
        check(lat == 3, "R2 read latency", lat, 3);
        check(rd === ref_word(a), {req, " read data"}, rd, ref_word(a));
    endtask

    initial begin
        for (int w = 0; w < DEPTH; w++) begin
            mem[w] = 32'hA5000000 ^ (w * 32'h01010101);
            for (int i = 0; i < NL; i++) ref_b[w*NL + i] = mem[w][i*8 +: 8];
        end
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(bus_ack === 1'b0 && mem_we === 1'b0, "R1 reset outputs", {bus_ack, mem_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_ack === 1'b0 && mem_we === 1'b0, "R1 idle outputs", {bus_ack, mem_we}, 0);

        do_read(5, "R2 R11");
        // R6: single lanes, each in its own position
        for (int l = 0; l < NL; l++) begin
            do_write(7, 32'h11223344 + l, 4'(1 << l), 1'b0, "R6");
            do_read(7, "R6 R7");
        end
        // R7: two alternate lanes
        do_write(8, 32'hDEADBEEF, 4'b1010, 1'b0, "R7");
        do_read(8, "R7");
        // R8: no lanes, write-back unchanged
        do_write(9, 32'hFFFFFFFF, 4'b0000, 1'b0, "R8");
        do_read(9, "R8");
        // R9: all lanes
        do_write(10, 32'hCAFEF00D, 4'b1111, 1'b0, "R9");
        do_read(10, "R9");
        // R10: bus scrambled while the access is busy
        do_write(11, 32'h0BADC0DE, 4'b0110, 1'b1, "R10");
        do_read(11, "R10");
        do_read(~11 & (DEPTH - 1), "R10 other address");
        // R3 R6 R7: random mixed traffic over a few words
        for (int n = 0; n < 300; n++) begin
            int a = int'($urandom_range(0, 15));
            if ($urandom_range(0, 2) != 0)
                do_write(a, $urandom, 4'($urandom), 1'b0, "R3");
            else
                do_read(a, "R6 R7 mixed");
        end
        for (int a = 0; a < 16; a++) do_read(a, "R7 final sweep");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule